// File: doc/BRIEF.md
# Symmetric FIR Pre-Add MAC Engine

This block is a streaming linear-phase FIR filter for an even tap count N whose coefficients are mirror-symmetric. It keeps the last N input samples as two circular half-length buffers. For every output it adds the two samples that share a coefficient, multiplies that 17-bit sum by the coefficient, and accumulates the product in a 40-bit accumulator. An output therefore costs N/2 multiply-accumulate steps, one per clock.

Samples enter through a valid/ready handshake. While one output is being computed, ready stays low, and it returns in the same cycle that the result strobe fires. The N/2 distinct coefficients are written through a simple write port into a linear register array: index k holds the coefficient shared by the k-th newest and the k-th oldest sample. The 16-bit result is bits [31:16] of the accumulator, clamped to the signed 16-bit range.

Top module: `sym_fir_engine`

## Requirements
- R1: After reset, smp_ready_o is 1, res_valid_o is 0, res_data_o is 0, and every delay-line entry reads as zero, so the first outputs see only the samples pushed since reset.
- R2: A sample is taken on a rising edge where smp_valid_i and smp_ready_o are both 1. smp_ready_o is 0 from the next cycle until the result for that sample is presented. A sample offered while smp_ready_o is 0 is ignored and never enters the delay line.
- R3: Each output equals sum over k=0..N/2-1 of h[k]*(x[n-k]+x[n-N+1-k... mirrored]), that is h[k]*(x[n-k]+x[n-N+1+k]), with x[n] the sample just taken. The accumulator starts from zero for each output.
- R4: res_data_o is the accumulator arithmetically shifted right by 16, clamped to 32767 when it is larger and to -32768 when it is smaller.
- R5: res_valid_o is a one-cycle pulse, raised exactly N/2+2 clock edges after the edge that took the sample.
- R6: A rising edge with coef_we_i at 1 stores coef_data_i (signed 16 bits) into coefficient index coef_addr_i, and later outputs use it as h[coef_addr_i].
- R7: The delay line keeps the N most recent samples in arrival order: a single nonzero sample followed by zeros produces outputs h[0],h[1],...,h[N/2-1],h[N/2-1],...,h[0] scaled by that sample, and zero afterwards.
- R8: The pair sum is formed at 17 bits, so two samples of -32768 give -65536 into the multiplier without wrapping.
- R9: smp_ready_o rises in the same cycle res_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample offered |
| smp_data_i | input | 16 | Signed input sample |
| smp_ready_o | output | 1 | Engine can take a sample |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | $clog2(N/2) | Coefficient index |
| coef_data_i | input | 16 | Signed coefficient value |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 16 | Saturated signed result |

## Verification
A unit impulse after reset walks through all N outputs and shows whether samples reach the right coefficient in the mirrored order and fall out after N pushes, which a wrong buffer pointer or a swapped half would break. A mixed-sign sequence with a stray sample offered during a busy window separates correct pairing and accumulator clearing from leakage of ignored input. Full-scale runs of the largest positive and negative samples against large coefficients tell the saturation paths apart, and a run of -32768 with a single coefficient distinguishes a 17-bit pre-add from one that wraps at 16 bits. A coefficient rewritten between outputs shows that index mapping and the write port agree.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } fir_state_e;
endpackage

// File: rtl/sym_fir_delay.sv
module sym_fir_delay #(
  parameter int HALF = 4,
  parameter int DW   = 16,
  localparam int IW  = $clog2(HALF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic signed [DW-1:0] din_i,
  input  logic [IW-1:0]        pair_i,
  output logic signed [DW-1:0] new_o,
  output logic signed [DW-1:0] old_o
);
  logic signed [DW-1:0] half_a [HALF];
  logic signed [DW-1:0] half_b [HALF];
  logic [IW-1:0] wp_q;
  logic [IW:0]   a_sum, b_sum, a_idx, b_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      for (int i = 0; i < HALF; i++) begin
        half_a[i] <= '0;
        half_b[i] <= '0;
      end
    end else if (push_i) begin
      // oldest of first half spills into the second half before overwrite
      half_b[wp_q] <= half_a[wp_q];
      half_a[wp_q] <= din_i;
      wp_q <= (wp_q == IW'(HALF-1)) ? '0 : wp_q + 1'b1;
    end
  end

  // newest walks backwards from wp-1, oldest walks forwards from wp
  always_comb begin
    a_sum = {1'b0, wp_q} + (IW+1)'(HALF-1) - {1'b0, pair_i};
    b_sum = {1'b0, wp_q} + {1'b0, pair_i};
    a_idx = (a_sum >= (IW+1)'(HALF)) ? a_sum - (IW+1)'(HALF) : a_sum;
    b_idx = (b_sum >= (IW+1)'(HALF)) ? b_sum - (IW+1)'(HALF) : b_sum;
  end

  assign new_o = half_a[a_idx[IW-1:0]];
  assign old_o = half_b[b_idx[IW-1:0]];
endmodule

// File: rtl/sym_fir_coef.sv
module sym_fir_coef #(
  parameter int HALF = 4,
  parameter int CW   = 16,
  localparam int IW  = $clog2(HALF)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IW-1:0]        waddr_i,
  input  logic signed [CW-1:0] wdata_i,
  input  logic [IW-1:0]        raddr_i,
  output logic signed [CW-1:0] rdata_o
);
  logic signed [CW-1:0] coef_q [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          coef_q[g] <= '0;
      else if (we_i && waddr_i == IW'(g))   coef_q[g] <= wdata_i;
    end
  end

  assign rdata_o = coef_q[raddr_i];
endmodule

// File: rtl/sym_fir_mac.sv
module sym_fir_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40,
  parameter int FRAC = 16,
  localparam int SW  = DW + 1,
  localparam int PW  = SW + CW,
  localparam int HW  = AW - FRAC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic signed [SW-1:0] psum_i,
  input  logic signed [CW-1:0] coef_i,
  output logic                 done_o,
  output logic                 res_valid_o,
  output logic signed [DW-1:0] res_data_o
);
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc_q, acc_base;
  logic                 done_q;
  logic [HW-1:0]        hi;
  logic signed [DW-1:0] sat;

  assign prod     = psum_i * coef_i;
  assign acc_base = first_i ? '0 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= vld_i && last_i;
      if (vld_i) acc_q <= acc_base + {{(AW-PW){prod[PW-1]}}, prod};
    end
  end

  assign hi = acc_q[AW-1:FRAC];
  always_comb begin
    if (!hi[HW-1] && (|hi[HW-2:DW-1]))
      sat = {1'b0, {(DW-1){1'b1}}};
    else if (hi[HW-1] && !(&hi[HW-2:DW-1]))
      sat = {1'b1, {(DW-1){1'b0}}};
    else
      sat = hi[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= done_q;
      if (done_q) res_data_o <= sat;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/sym_fir_engine.sv
module sym_fir_engine
  import sym_fir_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40,
  localparam int HALF = TAPS / 2,
  localparam int IW   = $clog2(HALF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  output logic          smp_ready_o,
  input  logic          coef_we_i,
  input  logic [IW-1:0] coef_addr_i,
  input  logic [CW-1:0] coef_data_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_data_o
);
  fir_state_e state_q;
  logic [IW-1:0] pair_q;
  logic push, mac_done, pair_last;
  logic signed [DW-1:0] smp_new, smp_old, res_s;
  logic signed [CW-1:0] coef_rd;
  logic signed [DW:0]   psum_q;
  logic signed [CW-1:0] coef_q;
  logic p_vld_q, p_first_q, p_last_q;

  assign push        = (state_q == ST_IDLE) && smp_valid_i;
  assign smp_ready_o = (state_q == ST_IDLE);
  assign pair_last   = (pair_q == IW'(HALF-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pair_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (smp_valid_i) begin
          state_q <= ST_RUN;
          pair_q  <= '0;
        end
        ST_RUN: begin
          pair_q <= pair_q + 1'b1;
          if (pair_last) state_q <= ST_WAIT;
        end
        ST_WAIT: if (mac_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sym_fir_delay #(.HALF(HALF), .DW(DW)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .din_i  (smp_data_i),
    .pair_i (pair_q),
    .new_o  (smp_new),
    .old_o  (smp_old)
  );

  sym_fir_coef #(.HALF(HALF), .CW(CW)) u_coef (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (coef_we_i),
    .waddr_i (coef_addr_i),
    .wdata_i (coef_data_i),
    .raddr_i (pair_q),
    .rdata_o (coef_rd)
  );

  // pre-add stage, overlaps the accumulate of the previous pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_q    <= '0;
      coef_q    <= '0;
      p_vld_q   <= 1'b0;
      p_first_q <= 1'b0;
      p_last_q  <= 1'b0;
    end else begin
      p_vld_q   <= (state_q == ST_RUN);
      p_first_q <= (pair_q == '0);
      p_last_q  <= pair_last;
      psum_q    <= {smp_new[DW-1], smp_new} + {smp_old[DW-1], smp_old};
      coef_q    <= coef_rd;
    end
  end

  sym_fir_mac #(.DW(DW), .CW(CW), .AW(AW), .FRAC(16)) u_mac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (p_vld_q),
    .first_i     (p_first_q),
    .last_i      (p_last_q),
    .psum_i      (psum_q),
    .coef_i      (coef_q),
    .done_o      (mac_done),
    .res_valid_o (res_valid_o),
    .res_data_o  (res_s)
  );

  assign res_data_o = res_s;
endmodule

// File: rtl/sym_fir_chk.sv
module sym_fir_chk #(
  parameter int TAPS = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        smp_valid_i,
  input logic        smp_ready_o,
  input logic        res_valid_o,
  input logic [15:0] res_data_o
);
  localparam int HALF = TAPS / 2;
  logic [7:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         since_q <= 8'hff;
    else if (smp_valid_i && smp_ready_o) since_q <= '0;
    else if (since_q != 8'hff)           since_q <= since_q + 1'b1;
  end

  initial assert (TAPS % 2 == 0 && TAPS >= 4 && TAPS <= 64);

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o); // R2
  AST_RESULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R5
  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (since_q == 8'(HALF + 2))); // R5
  AST_READY_WITH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_ready_o) |-> res_valid_o); // R9
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o && !$past(res_valid_o) |-> $stable(res_data_o)); // R4
endmodule

bind sym_fir_engine sym_fir_chk #(.TAPS(TAPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_ready_o (smp_ready_o),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o)
);

// File: tb/sim_sym_fir_engine.sv
`timescale 1ns/1ps
module sim_sym_fir_engine;
  localparam int TAPS = 8;
  localparam int HALF = TAPS / 2;
  localparam int IW   = $clog2(HALF);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic smp_valid = 1'b0, coef_we = 1'b0;
  logic [15:0] smp_data = '0, coef_data = '0;
  logic [IW-1:0] coef_addr = '0;
  logic smp_ready, res_valid;
  logic [15:0] res_data;

  int n_chk = 0, n_fail = 0;
  int hist [TAPS];
  int mc [HALF];

  always #4 clk = ~clk;

  sym_fir_engine #(.TAPS(TAPS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_ready_o(smp_ready),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .res_valid_o(res_valid), .res_data_o(res_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_out();
    longint acc = 0;
    longint y;
    for (int k = 0; k < HALF; k++)
      acc += longint'(mc[k]) * longint'(hist[k] + hist[TAPS-1-k]);
    y = acc >>> 16;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic set_coef(input int idx, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = IW'(idx); coef_data = 16'(val);
    @(negedge clk);
    coef_we = 1'b0;
    mc[idx] = val;
  endtask

  // push one sample; optional stray sample while busy; checks latency, data, ready
  task automatic push(input int val, input bit stray, input string req);
    int lat;
    @(negedge clk);
    chk(smp_ready == 1'b1, "R2", smp_ready, 1);
    smp_valid = 1'b1; smp_data = 16'(val);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int i = TAPS-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = val;
    lat = 0;
    while (!res_valid && lat < 100) begin
      chk(smp_ready == 1'b0, "R2", smp_ready, 0);
      if (stray && lat == 1) begin smp_valid = 1'b1; smp_data = 16'h5a5a; end
      else smp_valid = 1'b0;
      @(negedge clk);
      lat++;
    end
    smp_valid = 1'b0;
    chk(lat == HALF + 2, "R5", lat, HALF + 2);
    chk(smp_ready == 1'b1, "R9", smp_ready, 1);
    chk($signed(res_data) == model_out(), req, $signed(res_data), model_out());
    @(negedge clk);
    chk(res_valid == 1'b0, "R5", res_valid, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    for (int k = 0; k < HALF; k++) mc[k] = 0;
    #1;
    chk(smp_ready == 1'b1, "R1", smp_ready, 1);
    chk(res_valid == 1'b0, "R1", res_valid, 0);
    chk(res_data == 16'h0, "R1", res_data, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(smp_ready == 1'b1 && res_valid == 1'b0, "R1", smp_ready, 1);
  endtask

  task automatic t_impulse();
    set_coef(0, 16'sh2000); set_coef(1, -4096); set_coef(2, 2048); set_coef(3, 16384);
    push(16384, 1'b0, "R1");
    for (int i = 1; i < TAPS; i++) push(0, 1'b0, "R7");
    push(0, 1'b0, "R7");
  endtask

  task automatic t_mixed();
    int seq [6] = '{1200, -3000, 25000, -17, 9000, -22222};
    foreach (seq[i]) push(seq[i], (i % 2) == 0, "R3");
    push(777, 1'b0, "R2");
  endtask

  task automatic t_coef_write();
    set_coef(2, 28672);
    push(-5000, 1'b0, "R6");
    set_coef(0, -32768);
    push(3000, 1'b0, "R6");
  endtask

  task automatic t_preadd();
    for (int k = 0; k < HALF; k++) set_coef(k, k == 0 ? 32767 : 0);
    for (int i = 0; i < TAPS; i++) push(-32768, 1'b0, "R8");
    chk($signed(res_data) == -32767, "R8", $signed(res_data), -32767);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < HALF; k++) set_coef(k, 32767);
    for (int i = 0; i < TAPS; i++) push(32767, 1'b0, "R4");
    chk($signed(res_data) == 32767, "R4", $signed(res_data), 32767);
    for (int i = 0; i < TAPS; i++) push(-32768, 1'b0, "R4");
    chk($signed(res_data) == -32768, "R4", $signed(res_data), -32768);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_mixed();
    t_coef_write();
    t_preadd();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule